// File: doc/BRIEF.md
# Banked Lane Scratchpad with Conflict Serialization

This block is an on-chip SRAM scratchpad that serves a group of lanes with one request at a time. Each lane gives a byte address and an enable bit. The storage is split into word-wide banks, and consecutive words sit in consecutive banks. When the lanes of a request fall into different banks, the request is served in a single cycle. When several lanes address different words of the same bank, the block serializes them, one distinct word per bank per cycle.

Lanes that name the very same word share one access, which is a broadcast. So the number of service cycles is the largest count of distinct words asked of any single bank. That count is returned with the results as the conflict degree. A request either reads words or writes them. In a write, lanes that collide on one word resolve to the data of the highest-numbered lane. The request side uses a valid/ready handshake, and the block takes a new request only once the previous one has finished. Results come back together in one cycle, marked by a done strobe, with a valid bit for each lane.

Top module: `bank_scratchpad`

## Requirements
- R1: A byte address maps to word = address >> 2. The bank is the word modulo 32 (word bits [4:0]) and the row within that bank is word / 32. The two lowest address bits are ignored.
- R2: A request whose enabled lanes all fall in different banks finishes after one service cycle and reports degree 1.
- R3: Enabled lanes that name distinct words in one bank are served one word per cycle. The service cycle count and the reported degree both equal the largest number of distinct words requested of any bank. Lanes spaced 128 bytes apart all share a bank, and 32 such distinct words give degree 32.
- R4: Lanes that name the same word are served together in one cycle and count once toward the degree.
- R5: Lanes whose enable is low take no part in the degree and never have their response valid bit set.
- R6: A request with no lane enabled finishes after one service cycle with degree 0 and no lane valid bits.
- R7: req_ready is high only while the block is idle. A request presented while a previous one is in service is not taken and has no effect on memory.
- R8: rsp_done is a one-cycle pulse that comes in the cycle after the last service cycle. In that cycle, each enabled lane of a read request has its valid bit set and its rsp_rdata slice (lane n at bits [32n+31:32n]) holds the word stored at its address.
- R9: A write request stores each enabled lane's data using the same per-bank schedule and the same degree as a read. When enabled lanes name one word, the highest-numbered such lane's data is kept. Write requests return no lane valid bits.
- R10: After reset, req_ready is high, rsp_done is low and no lane valid bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_lane_en | input | LANES | Per-lane enable |
| req_addr | input | LANES*AW | Per-lane byte address, lane n at bits [AW*n+AW-1:AW*n] |
| req_wdata | input | LANES*DW | Per-lane write data, lane n at bits [DW*n+DW-1:DW*n] |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_lane_valid | output | LANES | Per-lane read data valid, set only during rsp_done |
| rsp_rdata | output | LANES*DW | Per-lane read data |
| rsp_degree | output | DEGW | Conflict degree of the completed request |

## Verification
The assertions assume that req_lane_en and req_write are stable at the edge where a request is accepted. They also assume that a request's addresses fall within the scratchpad, which holds by construction because the address width matches its capacity exactly. The bench drives every input at the falling edge and lowers req_valid just after the accepting edge. While a request is in service, it deliberately holds req_valid high with a conflicting write, so that the handshake's refusal is observed at the ports and then confirmed by reading the same words back. Expected degrees come from counting distinct words per bank across the enabled lanes. Expected data comes from a word-level model updated lane by lane in ascending order.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

   typedef enum logic {
      BSP_IDLE  = 1'b0,
      BSP_SERVE = 1'b1
   } bsp_state_e;

   localparam int BSP_DEF_LANES      = 32;
   localparam int BSP_DEF_BANKS      = 32;
   localparam int BSP_DEF_WORD_BYTES = 4;
   localparam int BSP_DEF_ROWS       = 32;

endpackage

// File: rtl/bsp_bank_pick.sv
module bsp_bank_pick #(
   parameter int LANES    = 32,
   parameter int WW       = 10,
   parameter int BANKB    = 5,
   parameter int DW       = 32,
   parameter int BANK_ID  = 0,
   parameter bit PICK_LOW = 1'b1
) (
   input  logic [LANES-1:0]    pend,
   input  logic [LANES*WW-1:0] words,
   input  logic [LANES*DW-1:0] wdata,
   output logic                hit,
   output logic [WW-BANKB-1:0] row,
   output logic [LANES-1:0]    grp,
   output logic [DW-1:0]       wr_word
);

   localparam logic [BANKB-1:0] MY_BANK = BANKB'(BANK_ID);

   logic [LANES-1:0] inbank;
   logic [WW-1:0]    sel_word;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         inbank[l] = pend[l] && (words[l*WW +: BANKB] == MY_BANK);
      end
   end

   generate
      if (PICK_LOW) begin : g_low_first
         always_comb begin
            sel_word = '0;
            for (int l = LANES-1; l >= 0; l--) begin
               if (inbank[l]) sel_word = words[l*WW +: WW];
            end
         end
      end else begin : g_high_first
         always_comb begin
            sel_word = '0;
            for (int l = 0; l < LANES; l++) begin
               if (inbank[l]) sel_word = words[l*WW +: WW];
            end
         end
      end
   endgenerate

   always_comb begin
      wr_word = '0;
      for (int l = 0; l < LANES; l++) begin
         grp[l] = inbank[l] && (words[l*WW +: WW] == sel_word);
         if (grp[l]) wr_word = wdata[l*DW +: DW];
      end
   end

   assign hit = |inbank;
   assign row = sel_word[WW-1:BANKB];

endmodule

// File: rtl/bsp_bank_store.sv
module bsp_bank_store #(
   parameter int ROWS = 32,
   parameter int DW   = 32,
   localparam int RB  = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [RB-1:0] row,
   input  logic [DW-1:0] wd,
   output logic [DW-1:0] rd
);

   logic [DW-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we) mem[row] <= wd;
   end

   assign rd = mem[row];

endmodule

// File: rtl/bsp_lane_route.sv
module bsp_lane_route #(
   parameter int BANKS = 32,
   parameter int BANKB = 5,
   parameter int DW    = 32
) (
   input  logic [BANKB-1:0]    bank,
   input  logic [BANKS*DW-1:0] bank_rd,
   input  logic [BANKS-1:0]    grp_col,
   output logic                served,
   output logic [DW-1:0]       rd
);

   assign served = |grp_col;
   assign rd     = bank_rd[bank*DW +: DW];

endmodule

// File: rtl/bank_scratchpad.sv
module bank_scratchpad #(
   parameter int  LANES      = bsp_pkg::BSP_DEF_LANES,
   parameter int  BANKS      = bsp_pkg::BSP_DEF_BANKS,
   parameter int  WORD_BYTES = bsp_pkg::BSP_DEF_WORD_BYTES,
   parameter int  ROWS       = bsp_pkg::BSP_DEF_ROWS,
   parameter bit  PICK_LOW   = 1'b1,
   localparam int OFFB  = $clog2(WORD_BYTES),
   localparam int BANKB = $clog2(BANKS),
   localparam int ROWB  = $clog2(ROWS),
   localparam int WW    = BANKB + ROWB,
   localparam int AW    = OFFB + WW,
   localparam int DW    = 8 * WORD_BYTES,
   localparam int DEGW  = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [LANES-1:0]    req_lane_en,
   input  logic [LANES*AW-1:0] req_addr,
   input  logic [LANES*DW-1:0] req_wdata,
   output logic                rsp_done,
   output logic [LANES-1:0]    rsp_lane_valid,
   output logic [LANES*DW-1:0] rsp_rdata,
   output logic [DEGW-1:0]     rsp_degree
);
   import bsp_pkg::*;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("bank_scratchpad: LANES must be at least 1");
      end
      if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
         $error("bank_scratchpad: BANKS must be a power of two, at least 2");
      end
      if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
         $error("bank_scratchpad: ROWS must be a power of two, at least 2");
      end
      if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("bank_scratchpad: WORD_BYTES must be a power of two, at least 2");
      end
   endgenerate

   // request state
   bsp_state_e          state_q;
   logic [LANES-1:0]    pend_q;
   logic [LANES*WW-1:0] words_q;
   logic [LANES*DW-1:0] wdata_q;
   logic                wr_q;
   logic [DEGW-1:0]     rounds_q;
   logic                done_q;
   logic [DEGW-1:0]     degree_q;
   logic [LANES-1:0]    rmask_q;
   logic [LANES*DW-1:0] rdata_q;

   // per bank
   logic                b_hit [BANKS];
   logic [ROWB-1:0]     b_row [BANKS];
   logic [LANES-1:0]    b_grp [BANKS];
   logic [DW-1:0]       b_wd  [BANKS];
   logic [BANKS-1:0]    b_we;
   logic [BANKS*DW-1:0] b_rd_flat;

   // per lane
   logic [BANKS-1:0]    lane_col [LANES];
   logic [LANES-1:0]    served;
   logic [DW-1:0]       lane_rd [LANES];

   logic                any_hit;
   logic [LANES-1:0]    pend_nx;
   logic [DEGW-1:0]     rounds_nx;
   logic                unused_low_bits;

   always_comb begin
      unused_low_bits = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         unused_low_bits = unused_low_bits ^ (^req_addr[l*AW +: OFFB]);
      end
   end

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         bsp_bank_pick #(
            .LANES    (LANES),
            .WW       (WW),
            .BANKB    (BANKB),
            .DW       (DW),
            .BANK_ID  (b),
            .PICK_LOW (PICK_LOW)
         ) u_pick (
            .pend    (pend_q),
            .words   (words_q),
            .wdata   (wdata_q),
            .hit     (b_hit[b]),
            .row     (b_row[b]),
            .grp     (b_grp[b]),
            .wr_word (b_wd[b])
         );

         assign b_we[b] = (state_q == BSP_SERVE) && wr_q && b_hit[b];

         bsp_bank_store #(
            .ROWS (ROWS),
            .DW   (DW)
         ) u_store (
            .clk (clk),
            .we  (b_we[b]),
            .row (b_row[b]),
            .wd  (b_wd[b]),
            .rd  (b_rd_flat[b*DW +: DW])
         );
      end
   endgenerate

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         for (int b = 0; b < BANKS; b++) begin
            lane_col[l][b] = b_grp[b][l];
         end
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         bsp_lane_route #(
            .BANKS (BANKS),
            .BANKB (BANKB),
            .DW    (DW)
         ) u_route (
            .bank    (words_q[l*WW +: BANKB]),
            .bank_rd (b_rd_flat),
            .grp_col (lane_col[l]),
            .served  (served[l]),
            .rd      (lane_rd[l])
         );
      end
   endgenerate

   always_comb begin
      any_hit = 1'b0;
      for (int b = 0; b < BANKS; b++) begin
         any_hit = any_hit | b_hit[b];
      end
   end

   assign pend_nx   = pend_q & ~served;
   assign rounds_nx = rounds_q + DEGW'(any_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= BSP_IDLE;
         pend_q   <= '0;
         words_q  <= '0;
         wdata_q  <= '0;
         wr_q     <= 1'b0;
         rounds_q <= '0;
         done_q   <= 1'b0;
         degree_q <= '0;
         rmask_q  <= '0;
         rdata_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            BSP_IDLE: begin
               if (req_valid) begin
                  state_q  <= BSP_SERVE;
                  pend_q   <= req_lane_en;
                  wr_q     <= req_write;
                  wdata_q  <= req_wdata;
                  rounds_q <= '0;
                  rmask_q  <= '0;
                  for (int l = 0; l < LANES; l++) begin
                     words_q[l*WW +: WW] <= req_addr[l*AW + OFFB +: WW];
                  end
               end
            end
            BSP_SERVE: begin
               pend_q   <= pend_nx;
               rounds_q <= rounds_nx;
               rmask_q  <= rmask_q | (served & {LANES{!wr_q}});
               for (int l = 0; l < LANES; l++) begin
                  if (served[l] && !wr_q) rdata_q[l*DW +: DW] <= lane_rd[l];
               end
               if (pend_nx == '0) begin
                  state_q  <= BSP_IDLE;
                  done_q   <= 1'b1;
                  degree_q <= rounds_nx;
               end
            end
            default: state_q <= BSP_IDLE;
         endcase
      end
   end

   assign req_ready      = (state_q == BSP_IDLE);
   assign rsp_done       = done_q;
   assign rsp_lane_valid = done_q ? rmask_q : '0;
   assign rsp_rdata      = rdata_q;
   assign rsp_degree     = degree_q;

endmodule

// File: rtl/bsp_check.sv
module bsp_check #(
   parameter int LANES = 32,
   parameter int DEGW  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             req_write,
   input logic [LANES-1:0] req_lane_en,
   input logic             rsp_done,
   input logic [LANES-1:0] rsp_lane_valid,
   input logic [DEGW-1:0]  rsp_degree
);

   logic [15:0]      busy_cnt;
   logic [LANES-1:0] read_lanes_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt     <= '0;
         read_lanes_q <= '0;
      end else if (req_valid && req_ready) begin
         busy_cnt     <= '0;
         read_lanes_q <= req_lane_en & {LANES{!req_write}};
      end else if (!req_ready) begin
         busy_cnt <= busy_cnt + 16'd1;
      end
   end

   // R7: an accepted request blocks the next one
   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R7: completion leaves the block idle
   assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

   // R8: done is a single-cycle pulse
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R3: service cycles match the reported degree
   assert_degree_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> ((16'(rsp_degree) == busy_cnt) || (rsp_degree == '0 && busy_cnt == 16'd1)));

   // R3: degree never exceeds the lane count
   assert_degree_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (32'(rsp_degree) <= LANES));

   // R5 / R9: only enabled lanes of a read request are marked valid
   assert_valid_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> ((rsp_lane_valid & ~read_lanes_q) == '0));

   // R6: a zero-degree request returns no lane data
   assert_empty_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_degree == '0) |-> (rsp_lane_valid == '0));

endmodule

bind bank_scratchpad bsp_check #(
   .LANES (LANES),
   .DEGW  (DEGW)
) u_bsp_check (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_write      (req_write),
   .req_lane_en    (req_lane_en),
   .rsp_done       (rsp_done),
   .rsp_lane_valid (rsp_lane_valid),
   .rsp_degree     (rsp_degree)
);

// File: tb/bank_scratchpad_test.sv
`timescale 1ns/1ps
module bank_scratchpad_test;

   localparam int LANES = 32;
   localparam int AW    = 12;
   localparam int DW    = 32;
   localparam int DEGW  = 6;
   localparam int NW    = 1024;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic                req_ready;
   logic                req_write = 1'b0;
   logic [LANES-1:0]    req_lane_en = '0;
   logic [LANES*AW-1:0] req_addr;
   logic [LANES*DW-1:0] req_wdata;
   logic                rsp_done;
   logic [LANES-1:0]    rsp_lane_valid;
   logic [LANES*DW-1:0] rsp_rdata;
   logic [DEGW-1:0]     rsp_degree;

   logic [AW-1:0] la [LANES];
   logic [DW-1:0] ld [LANES];
   logic          poke_on = 1'b0;

   logic [DW-1:0] model [NW];
   int nvec = 0;
   int nfail = 0;
   bit all_done = 0;

   int               got_cycles;
   logic [DEGW-1:0]  got_deg;
   logic [LANES-1:0] got_lv;
   logic [LANES*DW-1:0] got_data;

   always #2 clk = ~clk;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*AW +: AW]  = la[l];
         req_wdata[l*DW +: DW] = poke_on ? 32'hDEAD_BEEF : ld[l];
      end
   end

   bank_scratchpad uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_write      (req_write),
      .req_lane_en    (req_lane_en),
      .req_addr       (req_addr),
      .req_wdata      (req_wdata),
      .rsp_done       (rsp_done),
      .rsp_lane_valid (rsp_lane_valid),
      .rsp_rdata      (rsp_rdata),
      .rsp_degree     (rsp_degree)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int word_of(input int l);
      return int'(la[l] >> 2);
   endfunction

   function automatic int exp_degree();
      int worst = 0;
      for (int b = 0; b < 32; b++) begin
         int cnt = 0;
         for (int l = 0; l < LANES; l++) begin
            if (req_lane_en[l] && (word_of(l) % 32) == b) begin
               bit seen = 0;
               for (int k = 0; k < l; k++) begin
                  if (req_lane_en[k] && word_of(k) == word_of(l)) seen = 1;
               end
               if (!seen) cnt++;
            end
         end
         if (cnt > worst) worst = cnt;
      end
      return worst;
   endfunction

   // one request, waits for done, captures response
   task automatic run_req(input bit wr, input bit poke, input string tag);
      @(negedge clk);
      chk(tag, "ready before request", {63'd0, req_ready}, 64'd1);
      req_write = wr;
      req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      got_cycles = 0;
      while (got_cycles < 200) begin
         @(posedge clk);
         got_cycles++;
         @(negedge clk);
         if (rsp_done) begin
            poke_on   = 1'b0;
            req_valid = 1'b0;
            req_write = wr;
            got_deg   = rsp_degree;
            got_lv    = rsp_lane_valid;
            got_data  = rsp_rdata;
            break;
         end
         chk("R7", "ready while busy", {63'd0, req_ready}, 64'd0);
         if (poke) begin
            poke_on   = 1'b1;
            req_write = 1'b1;
            req_valid = 1'b1;
         end
      end
      poke_on   = 1'b0;
      req_valid = 1'b0;
   endtask

   task automatic check_resp(input string tag, input bit wr);
      int ed = exp_degree();
      int ec = (ed == 0) ? 1 : ed;
      logic [LANES-1:0] elv = wr ? '0 : req_lane_en;
      chk(tag, "degree", 64'(got_deg), 64'(ed));
      chk(tag, "service cycles", 64'(got_cycles), 64'(ec));
      chk(tag, "lane valid", 64'(got_lv), 64'(elv));
      if (!wr) begin
         for (int l = 0; l < LANES; l++) begin
            if (req_lane_en[l])
               chk(tag, $sformatf("lane %0d data", l),
                   64'(got_data[l*DW +: DW]), 64'(model[word_of(l)]));
         end
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (req_lane_en[l]) model[word_of(l)] = ld[l];
         end
      end
   endtask

   function automatic logic [DW-1:0] pattern(input int w);
      return (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk("R10", "ready after reset", {63'd0, req_ready}, 64'd1);
      chk("R10", "done after reset", {63'd0, rsp_done}, 64'd0);
      chk("R10", "lane valid after reset", 64'(rsp_lane_valid), 64'd0);
   endtask

   task automatic t_fill();
      for (int r = 0; r < 32; r++) begin
         req_lane_en = '1;
         for (int l = 0; l < LANES; l++) begin
            la[l] = AW'((r*32 + l) << 2);
            ld[l] = pattern(r*32 + l);
         end
         run_req(1'b1, 1'b0, "R9");
         check_resp("R9", 1'b1);
      end
   endtask

   task automatic t_linear();
      req_lane_en = '1;
      for (int l = 0; l < LANES; l++) la[l] = AW'(((100 + l) << 2) | (l % 4));
      run_req(1'b0, 1'b0, "R2");
      check_resp("R2", 1'b0);
      check_resp("R1", 1'b0);
   endtask

   task automatic t_stride128(input bit poke);
      req_lane_en = '1;
      for (int l = 0; l < LANES; l++) la[l] = AW'((l*32 + 5) << 2);
      run_req(1'b0, poke, "R3");
      check_resp("R3", 1'b0);
   endtask

   task automatic t_broadcast();
      req_lane_en = '1;
      for (int l = 0; l < LANES; l++) la[l] = AW'(77 << 2);
      run_req(1'b0, 1'b0, "R4");
      check_resp("R4", 1'b0);
   endtask

   task automatic t_mixed();
      req_lane_en = '1;
      for (int l = 0; l < LANES; l++) begin
         if (l < 16) la[l] = AW'((((l % 4) * 32) + 3) << 2);
         else        la[l] = AW'((200 + l) << 2);
      end
      run_req(1'b0, 1'b0, "R4");
      chk("R4", "mixed degree", 64'(got_deg), 64'd5);
      check_resp("R4", 1'b0);
   endtask

   task automatic t_stride2();
      req_lane_en = '1;
      for (int l = 0; l < LANES; l++) la[l] = AW'((2*l) << 2);
      run_req(1'b0, 1'b0, "R3");
      chk("R3", "stride-2 degree", 64'(got_deg), 64'd2);
      check_resp("R3", 1'b0);
   endtask

   task automatic t_masked();
      req_lane_en = 32'h5555_5555;
      for (int l = 0; l < LANES; l++) la[l] = AW'((l*32 + 9) << 2);
      run_req(1'b0, 1'b0, "R5");
      chk("R5", "masked degree", 64'(got_deg), 64'd16);
      check_resp("R5", 1'b0);
   endtask

   task automatic t_empty();
      req_lane_en = '0;
      for (int l = 0; l < LANES; l++) la[l] = AW'((l*32) << 2);
      run_req(1'b0, 1'b0, "R6");
      check_resp("R6", 1'b0);
   endtask

   task automatic t_collide();
      req_lane_en = '1;
      for (int l = 0; l < LANES; l++) begin
         la[l] = AW'(300 << 2);
         ld[l] = 32'(1000 + l);
      end
      run_req(1'b1, 1'b0, "R9");
      check_resp("R9", 1'b1);
      run_req(1'b0, 1'b0, "R9");
      chk("R9", "highest lane kept", 64'(got_data[DW-1:0]), 64'd1031);
      check_resp("R8", 1'b0);
   endtask

   initial begin
      for (int l = 0; l < LANES; l++) begin
         la[l] = '0;
         ld[l] = '0;
      end
      for (int w = 0; w < NW; w++) model[w] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_linear();
      t_stride128(1'b1);
      t_stride128(1'b0);
      t_broadcast();
      t_mixed();
      t_stride2();
      t_masked();
      t_empty();
      t_collide();
      all_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!all_done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

endmodule